// File: doc/BRIEF.md
# Per-Task Deadline Monitor with Stepped Deadline Table

This block watches the deadlines of a set of tasks inside a repeating scheduling round. A shared round position advances on each time-base tick and wraps at a configurable round length. Each task has one deadline cell. The cell arms when the task's start strobe arrives and disarms when the task's done strobe arrives. If the round position reaches the cell's deadline point while the cell is still armed, the block reports a violation. A deadline that is met produces no report at all.

Each cell can run in one of two modes. In direct mode it uses one deadline point, and that point repeats every round. In stepped mode one cell serves all of the task's deadlines in a round. A small table holds the distance from each deadline to the next. A timely completion, or a violation, moves the cell on to its next point, and the cell's index goes back to the first entry after the last deadline and at every round boundary. Software fills the table through a write port. The mode and the last-entry index for each task are static configuration inputs.

Top module: `deadline_monitor`

## Requirements
- R1: While reset is high and on the first cycle after it, `viol_valid_o` and `viol_mask_o` are zero. Reset disarms every cell, clears every index to 0 and clears every table entry to 0.
- R2: The round position starts at 0 and increments only on cycles where `tick_i` is 1. On a tick taken at position `round_len_i`-1 it returns to 0. A cell expires only on a cycle where `tick_i` is 1 and the position equals the cell's current deadline point.
- R3: In direct mode (`mux_en_i[t]`=0) the deadline point is table entry 0 of task t. It applies in every round, and violations report index 0.
- R4: An armed cell that expires without a done strobe in the same cycle raises a violation. On the following cycle `viol_valid_o` is 1 for one cycle, together with the task ID and the deadline index that was current.
- R5: A done strobe while the cell is armed disarms it with no report. This includes a done strobe in the same cycle as the expiry.
- R6: An expiry of a cell that is not armed produces no report.
- R7: A violation disarms the cell. No further report comes for that task until a new start strobe.
- R8: In stepped mode, a timely completion or a violation advances the index. The new deadline point is the old point plus the table entry at the new index. When the index is at or beyond `last_idx_i[t]`, it returns to 0 and the point becomes entry 0.
- R9: A tick that wraps the round position resets the index of every stepped cell to 0.
- R10: If several cells violate in the same cycle, `viol_mask_o` shows all of them (bit t for task t). `viol_task_o` and `viol_idx_o` report the lowest task number.
- R11: A write with `cfg_we_i`=1 stores `cfg_delta_i` at entry (`cfg_task_i`, `cfg_idx_i`). The cells use the new value from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Time-base tick; advances the round position |
| round_len_i | input | TIME_W | Round length in ticks (at least 1) |
| mux_en_i | input | NUM_TASKS | Per-task stepped-mode enable |
| last_idx_i | input | NUM_TASKS*IDX_W | Per-task index of the last deadline in a round |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_task_i | input | TASK_W | Table write task number |
| cfg_idx_i | input | IDX_W | Table write entry number |
| cfg_delta_i | input | TIME_W | Table write data (deadline distance) |
| start_i | input | NUM_TASKS | Per-task start strobe (arms the cell) |
| done_i | input | NUM_TASKS | Per-task completion strobe |
| viol_valid_o | output | 1 | One-cycle violation pulse |
| viol_task_o | output | TASK_W | Task number of the reported violation |
| viol_idx_o | output | IDX_W | Deadline index of the reported violation |
| viol_mask_o | output | NUM_TASKS | All tasks that violated in that cycle |

## Verification
The assertions assume that `mux_en_i` and `last_idx_i` do not change while a report is in flight. They also assume that `round_len_i` is never smaller than the current round position plus one, so that the position wraps. The stimulus changes these inputs only when no task is armed, and it changes the round length only early in a round. Start and done strobes are single-cycle pulses driven between clock edges. The randomized phase lets start, done and tick land on any cycle, including the expiry cycle. This exercises the rule that a done strobe wins over an expiry in the same cycle, and the rule that a start strobe re-arms a cell.

// File: rtl/dlm_pkg.sv
package dlm_pkg;

  // What a deadline cell does with its table index on a given cycle.
  typedef enum logic [1:0] {
    IDX_HOLD  = 2'd0,
    IDX_STEP  = 2'd1,
    IDX_CLEAR = 2'd2
  } idx_act_e;

endpackage

// File: rtl/dlm_round_timer.sv
module dlm_round_timer #(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] round_len_i,
  output logic [TIME_W-1:0] pos_o,
  output logic              wrap_o
);

  logic [TIME_W-1:0] pos_q;

  // The tick taken at the last position of the round closes it.
  assign wrap_o = tick_i && (pos_q == round_len_i - TIME_W'(1));
  assign pos_o  = pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (tick_i) begin
      if (wrap_o) pos_q <= '0;
      else        pos_q <= pos_q + TIME_W'(1);
    end
  end

endmodule

// File: rtl/dlm_delta_table.sv
module dlm_delta_table #(
  parameter int NUM_TASKS = 4,
  parameter int MAX_DL    = 4,
  parameter int TIME_W    = 16,
  localparam int TASK_W   = $clog2(NUM_TASKS),
  localparam int IDX_W    = $clog2(MAX_DL),
  localparam int DEPTH    = NUM_TASKS * MAX_DL
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we_i,
  input  logic [TASK_W-1:0]        task_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [TIME_W-1:0]        data_i,
  output logic [DEPTH*TIME_W-1:0]  rows_o
);

  logic [TIME_W-1:0] mem [DEPTH];
  logic [TASK_W+IDX_W-1:0] waddr;

  assign waddr = {task_i, idx_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i && (int'(waddr) < DEPTH)) begin
      mem[waddr] <= data_i;
    end
  end

  // Every cell reads all of its own entries at once.
  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    assign rows_o[g*TIME_W +: TIME_W] = mem[g];
  end

endmodule

// File: rtl/dlm_cell.sv
module dlm_cell
  import dlm_pkg::*;
#(
  parameter int MAX_DL  = 4,
  parameter int TIME_W  = 16,
  localparam int IDX_W  = $clog2(MAX_DL)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic                     done_i,
  input  logic                     tick_i,
  input  logic                     wrap_i,
  input  logic [TIME_W-1:0]        pos_i,
  input  logic                     mux_en_i,
  input  logic [IDX_W-1:0]         last_idx_i,
  input  logic [MAX_DL*TIME_W-1:0] deltas_i,
  output logic                     fire_o,
  output logic [IDX_W-1:0]         idx_o
);

  logic              armed_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  cur_idx;
  logic [TIME_W-1:0] cum [MAX_DL];
  logic [TIME_W-1:0] point;
  logic              expire;
  logic              timely;
  idx_act_e          act;

  // Direct mode always sits on entry 0.
  assign cur_idx = mux_en_i ? idx_q : '0;

  // Deadline point for each index: running sum of the distances.
  always_comb begin
    logic [TIME_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < MAX_DL; k++) begin
      acc    = acc + deltas_i[k*TIME_W +: TIME_W];
      cum[k] = acc;
    end
  end

  assign point  = cum[cur_idx];
  assign expire = tick_i && (pos_i == point);
  assign timely = armed_q && done_i;
  assign fire_o = armed_q && !done_i && expire;
  assign idx_o  = cur_idx;

  always_comb begin
    if (!mux_en_i || wrap_i)  act = IDX_CLEAR;
    else if (timely || fire_o) act = (cur_idx >= last_idx_i) ? IDX_CLEAR : IDX_STEP;
    else                      act = IDX_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      armed_q <= start_i || (armed_q && !done_i && !expire);
      case (act)
        IDX_CLEAR: idx_q <= '0;
        IDX_STEP:  idx_q <= cur_idx + IDX_W'(1);
        default:   idx_q <= idx_q;
      endcase
    end
  end

endmodule

// File: rtl/dlm_report.sv
module dlm_report #(
  parameter int NUM_TASKS = 4,
  parameter int IDX_W     = 2,
  localparam int TASK_W   = $clog2(NUM_TASKS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_TASKS-1:0]       fire_i,
  input  logic [NUM_TASKS*IDX_W-1:0] idx_i,
  output logic                       valid_o,
  output logic [TASK_W-1:0]          task_o,
  output logic [IDX_W-1:0]           idx_o,
  output logic [NUM_TASKS-1:0]       mask_o
);

  logic [TASK_W-1:0] sel;
  logic [IDX_W-1:0]  sel_idx;

  // Scan from the top so the lowest firing task is the one kept.
  always_comb begin
    sel     = '0;
    sel_idx = '0;
    for (int t = NUM_TASKS - 1; t >= 0; t--) begin
      if (fire_i[t]) begin
        sel     = TASK_W'(t);
        sel_idx = idx_i[t*IDX_W +: IDX_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      task_o  <= '0;
      idx_o   <= '0;
      mask_o  <= '0;
    end else begin
      valid_o <= |fire_i;
      task_o  <= sel;
      idx_o   <= sel_idx;
      mask_o  <= fire_i;
    end
  end

endmodule

// File: rtl/deadline_monitor.sv
module deadline_monitor #(
  parameter int NUM_TASKS = 4,
  parameter int MAX_DL    = 4,
  parameter int TIME_W    = 16,
  localparam int TASK_W   = $clog2(NUM_TASKS),
  localparam int IDX_W    = $clog2(MAX_DL),
  localparam int ROW_W    = MAX_DL * TIME_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick_i,
  input  logic [TIME_W-1:0]          round_len_i,
  input  logic [NUM_TASKS-1:0]       mux_en_i,
  input  logic [NUM_TASKS*IDX_W-1:0] last_idx_i,
  input  logic                       cfg_we_i,
  input  logic [TASK_W-1:0]          cfg_task_i,
  input  logic [IDX_W-1:0]           cfg_idx_i,
  input  logic [TIME_W-1:0]          cfg_delta_i,
  input  logic [NUM_TASKS-1:0]       start_i,
  input  logic [NUM_TASKS-1:0]       done_i,
  output logic                       viol_valid_o,
  output logic [TASK_W-1:0]          viol_task_o,
  output logic [IDX_W-1:0]           viol_idx_o,
  output logic [NUM_TASKS-1:0]       viol_mask_o
);

  logic [TIME_W-1:0]          pos;
  logic                       wrap;
  logic [NUM_TASKS*ROW_W-1:0] rows;
  logic [NUM_TASKS-1:0]       fire;
  logic [NUM_TASKS*IDX_W-1:0] cell_idx;

  dlm_round_timer #(.TIME_W(TIME_W)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .round_len_i (round_len_i),
    .pos_o       (pos),
    .wrap_o      (wrap)
  );

  dlm_delta_table #(
    .NUM_TASKS (NUM_TASKS),
    .MAX_DL    (MAX_DL),
    .TIME_W    (TIME_W)
  ) u_table (
    .clk    (clk),
    .rst    (rst),
    .we_i   (cfg_we_i),
    .task_i (cfg_task_i),
    .idx_i  (cfg_idx_i),
    .data_i (cfg_delta_i),
    .rows_o (rows)
  );

  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_cell
    dlm_cell #(.MAX_DL(MAX_DL), .TIME_W(TIME_W)) u_cell (
      .clk        (clk),
      .rst        (rst),
      .start_i    (start_i[t]),
      .done_i     (done_i[t]),
      .tick_i     (tick_i),
      .wrap_i     (wrap),
      .pos_i      (pos),
      .mux_en_i   (mux_en_i[t]),
      .last_idx_i (last_idx_i[t*IDX_W +: IDX_W]),
      .deltas_i   (rows[t*ROW_W +: ROW_W]),
      .fire_o     (fire[t]),
      .idx_o      (cell_idx[t*IDX_W +: IDX_W])
    );
  end

  dlm_report #(.NUM_TASKS(NUM_TASKS), .IDX_W(IDX_W)) u_report (
    .clk     (clk),
    .rst     (rst),
    .fire_i  (fire),
    .idx_i   (cell_idx),
    .valid_o (viol_valid_o),
    .task_o  (viol_task_o),
    .idx_o   (viol_idx_o),
    .mask_o  (viol_mask_o)
  );

endmodule

// File: rtl/deadline_monitor_chk.sv
module deadline_monitor_chk #(
  parameter int NUM_TASKS = 4,
  parameter int IDX_W     = 2,
  parameter int TASK_W    = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 tick_i,
  input logic [NUM_TASKS-1:0] mux_en_i,
  input logic [NUM_TASKS-1:0] start_i,
  input logic [NUM_TASKS-1:0] done_i,
  input logic                 viol_valid_o,
  input logic [TASK_W-1:0]    viol_task_o,
  input logic [IDX_W-1:0]     viol_idx_o,
  input logic [NUM_TASKS-1:0] viol_mask_o
);

  logic [NUM_TASKS-1:0] mux_q;
  logic [NUM_TASKS-1:0] below;

  always_ff @(posedge clk) mux_q <= mux_en_i;

  assign below = (NUM_TASKS'(1) << viol_task_o) - NUM_TASKS'(1);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!viol_valid_o && viol_mask_o == '0));

  p_tick_only_r2: assert property (@(posedge clk) disable iff (rst)
    viol_valid_o |-> $past(tick_i));

  p_direct_idx_r3: assert property (@(posedge clk) disable iff (rst)
    (viol_valid_o && !mux_q[viol_task_o]) |-> (viol_idx_o == '0));

  p_mask_valid_r4: assert property (@(posedge clk) disable iff (rst)
    (viol_mask_o != '0) |-> viol_valid_o);

  p_task_in_mask_r10: assert property (@(posedge clk) disable iff (rst)
    viol_valid_o |-> viol_mask_o[viol_task_o]);

  p_lowest_r10: assert property (@(posedge clk) disable iff (rst)
    viol_valid_o |-> ((viol_mask_o & below) == '0));

  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_task
    p_done_silences_r5: assert property (@(posedge clk) disable iff (rst)
      done_i[t] |=> !viol_mask_o[t]);

    p_no_repeat_r7: assert property (@(posedge clk) disable iff (rst)
      (viol_mask_o[t] && !$past(start_i[t])) |=> !viol_mask_o[t]);
  end

endmodule

bind deadline_monitor deadline_monitor_chk #(
  .NUM_TASKS (NUM_TASKS),
  .IDX_W     (IDX_W),
  .TASK_W    (TASK_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tick_i       (tick_i),
  .mux_en_i     (mux_en_i),
  .start_i      (start_i),
  .done_i       (done_i),
  .viol_valid_o (viol_valid_o),
  .viol_task_o  (viol_task_o),
  .viol_idx_o   (viol_idx_o),
  .viol_mask_o  (viol_mask_o)
);

// File: tb/deadline_monitor_tb_top.sv
`timescale 1ns/1ps
module deadline_monitor_tb_top;

  localparam int NT = 4;
  localparam int MD = 4;
  localparam int TW = 16;
  localparam int IW = 2;
  localparam int KW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_r = 1'b0;
  logic [TW-1:0] round_len_r = 16'd100;
  logic [NT-1:0] mux_r = '0;
  logic [NT*IW-1:0] last_r = '0;
  logic          cfg_we_r = 1'b0;
  logic [KW-1:0] cfg_task_r = '0;
  logic [IW-1:0] cfg_idx_r = '0;
  logic [TW-1:0] cfg_delta_r = '0;
  logic [NT-1:0] start_r = '0;
  logic [NT-1:0] done_r = '0;

  logic          viol_valid_o;
  logic [KW-1:0] viol_task_o;
  logic [IW-1:0] viol_idx_o;
  logic [NT-1:0] viol_mask_o;

  always #4 clk = ~clk;

  deadline_monitor #(.NUM_TASKS(NT), .MAX_DL(MD), .TIME_W(TW)) dut_i (
    .clk (clk), .rst (rst), .tick_i (tick_r), .round_len_i (round_len_r),
    .mux_en_i (mux_r), .last_idx_i (last_r), .cfg_we_i (cfg_we_r),
    .cfg_task_i (cfg_task_r), .cfg_idx_i (cfg_idx_r), .cfg_delta_i (cfg_delta_r),
    .start_i (start_r), .done_i (done_r), .viol_valid_o (viol_valid_o),
    .viol_task_o (viol_task_o), .viol_idx_o (viol_idx_o), .viol_mask_o (viol_mask_o)
  );

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";

  // Behavioural reference state
  int m_pos;
  int m_idx [NT];
  bit m_armed [NT];
  int m_tbl [NT][MD];
  bit e_valid;
  int e_task, e_idx, e_mask;

  int vcount = 0;
  int last_task = 0, last_idx = 0, last_mask = 0;

  always @(posedge clk) begin : model
    int ix, pt, nmask, ntask, nidx, nix;
    bit expire, timely, fire, wrap;
    if (rst) begin
      m_pos = 0;
      for (int t = 0; t < NT; t++) begin
        m_idx[t] = 0; m_armed[t] = 0;
        for (int k = 0; k < MD; k++) m_tbl[t][k] = 0;
      end
      e_valid = 0; e_task = 0; e_idx = 0; e_mask = 0;
    end else begin
      wrap = tick_r && (m_pos == int'(round_len_r) - 1);
      nmask = 0; ntask = 0; nidx = 0;
      for (int t = NT - 1; t >= 0; t--) begin
        ix = mux_r[t] ? m_idx[t] : 0;
        pt = 0;
        for (int k = 0; k <= ix; k++) pt = (pt + m_tbl[t][k]) & 16'hFFFF;
        expire = tick_r && (m_pos == pt);
        timely = m_armed[t] && done_r[t];
        fire   = m_armed[t] && !done_r[t] && expire;
        if (fire) begin nmask |= (1 << t); ntask = t; nidx = ix; end
        m_armed[t] = start_r[t] || (m_armed[t] && !done_r[t] && !expire);
        if (!mux_r[t] || wrap) nix = 0;
        else if (timely || fire) nix = (ix >= int'(last_r[t*IW +: IW])) ? 0 : ix + 1;
        else nix = ix;
        m_idx[t] = nix;
      end
      e_valid = (nmask != 0); e_mask = nmask; e_task = ntask; e_idx = nidx;
      if (cfg_we_r) m_tbl[cfg_task_r][cfg_idx_r] = int'(cfg_delta_r);
      if (tick_r) m_pos = wrap ? 0 : ((m_pos + 1) & 16'hFFFF);
    end
  end

  // Compare against the model every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (viol_valid_o !== e_valid || int'(viol_mask_o) != e_mask ||
          (e_valid && (int'(viol_task_o) != e_task || int'(viol_idx_o) != e_idx))) begin
        errors++;
        $display("FAIL %s cycle compare: got v=%0d t=%0d i=%0d m=%0h exp v=%0d t=%0d i=%0d m=%0h",
                 cur_req, viol_valid_o, viol_task_o, viol_idx_o, viol_mask_o,
                 e_valid, e_task, e_idx, e_mask);
      end
      if (viol_valid_o) begin
        vcount++; last_task = viol_task_o; last_idx = viol_idx_o; last_mask = viol_mask_o;
      end
    end
  end

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d exp %0d", req, what, got, exp);
    end
  endtask

  task automatic wait_pos(input int p);
    do @(negedge clk); while (m_pos != p);
    #1;
  endtask

  task automatic pulse_start(input int t);
    start_r[t] = 1'b1; @(negedge clk); start_r[t] = 1'b0;
  endtask

  task automatic pulse_done(input int t);
    done_r[t] = 1'b1; @(negedge clk); done_r[t] = 1'b0;
  endtask

  task automatic wr(input int t, input int k, input int d);
    cfg_we_r = 1'b1; cfg_task_r = KW'(t); cfg_idx_r = IW'(k); cfg_delta_r = TW'(d);
    @(negedge clk); cfg_we_r = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : stim
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check("R1", "valid after reset", viol_valid_o, 0);
    check("R1", "mask after reset", viol_mask_o, 0);
    // Table: task0 35 (direct), task1 45 then +50 (stepped), tasks 2,3 at 70.
    mux_r = 4'b0010;
    last_r[1*IW +: IW] = 2'd1;
    wr(0, 0, 35); wr(1, 0, 45); wr(1, 1, 50); wr(2, 0, 70); wr(3, 0, 70);
    tick_r = 1'b1;

    cur_req = "R4";
    base = vcount;
    wait_pos(10); pulse_start(0);
    wait_pos(50);
    check("R4", "late task0 reports", vcount - base, 1);
    check("R4", "reported task", last_task, 0);
    check("R3", "direct index", last_idx, 0);
    cur_req = "R7";
    wait_pos(0); wait_pos(50);
    check("R7", "no second report", vcount - base, 1);

    cur_req = "R5";
    base = vcount;
    wait_pos(10); pulse_start(0); wait_pos(30); pulse_done(0);
    wait_pos(10); pulse_start(0); wait_pos(35); pulse_done(0);
    wait_pos(60);
    check("R5", "timely completion silent", vcount - base, 0);

    cur_req = "R8";
    base = vcount;
    wait_pos(0);
    wait_pos(10); pulse_start(1); wait_pos(40); pulse_done(1);
    wait_pos(60); pulse_start(1);
    wait_pos(99);
    check("R8", "stepped second deadline", vcount - base, 1);
    check("R8", "stepped task", last_task, 1);
    check("R8", "stepped index", last_idx, 1);

    cur_req = "R9";
    base = vcount;
    wait_pos(10); pulse_start(1); wait_pos(40); pulse_done(1);
    wait_pos(0);
    wait_pos(20); pulse_start(1);
    wait_pos(50);
    check("R9", "index cleared at wrap", vcount - base, 1);
    check("R9", "index after wrap", last_idx, 0);

    cur_req = "R6";
    base = vcount;
    wait_pos(0); wait_pos(99);
    check("R6", "unarmed cells silent", vcount - base, 0);

    cur_req = "R10";
    base = vcount;
    wait_pos(10); start_r = 4'b1100; @(negedge clk); start_r = '0;
    wait_pos(80);
    check("R10", "one pulse", vcount - base, 1);
    check("R10", "mask", last_mask, 12);
    check("R10", "lowest task", last_task, 2);

    cur_req = "R11";
    base = vcount;
    wait_pos(5); wr(0, 0, 20);
    wait_pos(10); pulse_start(0);
    wait_pos(30);
    check("R11", "new table value used", vcount - base, 1);

    cur_req = "R2";
    wait_pos(1); round_len_r = 16'd50;
    base = vcount;
    wait_pos(10); pulse_start(2);
    wait_pos(0); wait_pos(49); wait_pos(0); wait_pos(49);
    check("R2", "point beyond round never expires", vcount - base, 0);
    wait_pos(0); pulse_done(2);
    wait_pos(5); pulse_start(0); tick_r = 1'b0;
    repeat (30) @(negedge clk);
    #1;
    check("R2", "no expiry without ticks", vcount - base, 0);
    tick_r = 1'b1;
    wait_pos(30);
    check("R2", "expiry after ticks resume", vcount - base, 1);

    // Randomized phase: any strobe on any cycle, stepped tasks with 3 entries.
    cur_req = "R8";
    wait_pos(1); round_len_r = 16'd40;
    mux_r = 4'b0011; last_r = {2'd0, 2'd0, 2'd2, 2'd2};
    wr(0, 0, 8); wr(0, 1, 9); wr(0, 2, 11); wr(1, 1, 7); wr(1, 2, 12); wr(1, 0, 5);
    wr(2, 0, 17); wr(3, 0, 17);
    for (int c = 0; c < 4000; c++) begin
      start_r = '0; done_r = '0; tick_r = ($urandom_range(0, 3) != 0);
      for (int t = 0; t < NT; t++) begin
        if ($urandom_range(0, 15) == 0) start_r[t] = 1'b1;
        if ($urandom_range(0, 19) == 0) done_r[t] = 1'b1;
      end
      if ($urandom_range(0, 199) == 0) begin
        cfg_we_r = 1'b1; cfg_task_r = KW'($urandom_range(0, 3));
        cfg_idx_r = IW'($urandom_range(0, 3)); cfg_delta_r = TW'($urandom_range(1, 12));
      end else cfg_we_r = 1'b0;
      @(negedge clk);
    end
    start_r = '0; done_r = '0; cfg_we_r = 1'b0;
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule